// File: doc/BRIEF.md
# LED Blink PWM Generator

This block drives a single LED pin from a small register file. A selectable tick enable sets the pace: either a fast or a slow source, picked by one configuration bit. Software writes words over a simple strobe bus. The block can hold the pin low, hold it high, or produce a pulse train whose period and high time are both multiples of a programmable prescale.

In PWM mode a prescale counter divides the tick by LD+1. Each time it wraps, an 8-bit phase counter advances, so one period is 256·(LD+1) ticks. The pin is high while the phase is below the 8-bit duty value, and the codes 0 and 255 saturate to fully low and fully high. Duty writes take effect at once. Prescale writes land in a shadow register and reach the counters only at a period start, after software raises an update request. While the output is parked, the request is taken at once.

When the block leaves the off state, it can hold the pin low for a programmed number of ticks before it starts output. Two further registers exist only as plain storage: a 32-bit step size and a 16-bit interval. The pin is registered, so a change in state or registers shows on the pin one clock later.

Top module: `led_pwm_gen`

## Requirements
- R1: After reset the config word reads 0x00001400, every other register reads 0 and `led_o` is low.
- R2: Config bits [1:0] select the mode. Codes 0 and 1 keep `led_o` low whatever the duty. Code 3 keeps it high once any start-up hold has expired.
- R3: With mode 2 and a duty between 1 and 254, every window of 256·(LD+1) consecutive ticks holds exactly duty·(LD+1) high ticks, in one unbroken high run. LD is the active prescale.
- R4: With mode 2, duty 0 gives no high tick in a period and duty 255 gives all 256·(LD+1) ticks high.
- R5: A write to the delay word (offset 2, prescale in bits [11:0]) leaves the running period unchanged.
- R6: Writing 1 to config bit 6 requests a transfer. The held prescale becomes active at the next period start, or at once while the output is off or held, and bit 6 reads 1 until then and 0 afterwards. Writing 0 to bit 6 does not cancel a pending request.
- R7: A write to the limits word (offset 1, duty in bits [7:0]) changes `led_o` one clock after the write edge, without waiting for a period boundary.
- R8: Writing 1 to config bit 7 restarts the counters at phase 0, sets the active prescale to 0 and drops any pending transfer. Bit 7 always reads 0.
- R9: Reads return zero-extended words for every offset: config keeps bits [16:0], limits [15:0], delay [23:0], step size (offset 3) [31:0], interval (offset 4) [15:0] and output delay (offset 5) [7:0]. An unused offset reads 0, and `bus_rdata_o` is 0 when no read strobe is present.
- R10: Config bit 2 picks `fast_tick_i` when 1 and `slow_tick_i` when 0. The counters advance only on the picked tick.
- R11: Leaving the off state with output delay N holds `led_o` low for the first N ticks. With one tick every clock, the pin shows N+1 low cycles after the mode write edge, then starts at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fast_tick_i | input | 1 | Fast tick enable, one clock wide per tick |
| slow_tick_i | input | 1 | Slow tick enable, one clock wide per tick |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 3 | Word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the read strobe |
| led_o | output | 1 | LED pin, active high |

## Verification
A corrupt prescale or phase counter appears on the pin within one period as a high run or per-period high count that differs from duty·(LD+1). A shadow register that leaks into the active prescale changes the very next high run, before any update request. A pending flag that is stuck or cleared too early shows up in the config readback and in the length of the first period after the request. A hold counter that is off by one shifts the first high edge after the mode write by one cycle.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_ALT_OFF = 2'd1,
    MODE_PWM     = 2'd2,
    MODE_ON      = 2'd3
  } led_mode_e;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LIM  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DLY  = 3'd2;
  localparam logic [ADDR_W-1:0] A_STEP = 3'd3;
  localparam logic [ADDR_W-1:0] A_IVL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ODLY = 3'd5;

  localparam int unsigned CFG_W = 17;
  localparam logic [CFG_W-1:0] CFG_RESET = 17'h01400;

  localparam int unsigned B_FAST = 2;
  localparam int unsigned B_UPD  = 6;
  localparam int unsigned B_CLR  = 7;

endpackage

// File: rtl/led_pwm_regs.sv
module led_pwm_regs
  import led_pwm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned PH_W   = 8,
  parameter int unsigned HOLD_W = 8,
  parameter int unsigned LIM_W  = 16,
  parameter int unsigned DLY_W  = 24,
  parameter int unsigned STEP_W = 32,
  parameter int unsigned IVL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              commit_i,
  output logic [1:0]        mode_o,
  output logic              fast_sel_o,
  output logic              upd_pend_o,
  output logic              clr_o,
  output logic [PH_W-1:0]   duty_o,
  output logic [PRE_W-1:0]  hold_ld_o,
  output logic [HOLD_W-1:0] outdly_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [LIM_W-1:0]  lim_q;
  logic [DLY_W-1:0]  dly_q;
  logic [STEP_W-1:0] step_q;
  logic [IVL_W-1:0]  ivl_q;
  logic [HOLD_W-1:0] odly_q;
  logic              wr_cfg, keep_pend;
  logic [DATA_W-1:0] rdata_d;

  assign wr_cfg    = wr_i && (addr_i == A_CFG);
  assign clr_o     = wr_cfg && wdata_i[B_CLR];
  assign keep_pend = cfg_q[B_UPD] && !commit_i && !clr_o;

  // Next config word: request bit is sticky until taken, clear bit is a strobe only
  always_comb begin
    cfg_d = cfg_q;
    if (wr_cfg) begin
      cfg_d        = wdata_i[CFG_W-1:0];
      cfg_d[B_UPD] = wdata_i[B_UPD] | keep_pend;
      cfg_d[B_CLR] = 1'b0;
    end else begin
      cfg_d[B_UPD] = keep_pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= '0;
      dly_q  <= '0;
      step_q <= '0;
      ivl_q  <= '0;
      odly_q <= '0;
    end else if (wr_i) begin
      if (addr_i == A_LIM)  lim_q  <= wdata_i[LIM_W-1:0];
      if (addr_i == A_DLY)  dly_q  <= wdata_i[DLY_W-1:0];
      if (addr_i == A_STEP) step_q <= wdata_i[STEP_W-1:0];
      if (addr_i == A_IVL)  ivl_q  <= wdata_i[IVL_W-1:0];
      if (addr_i == A_ODLY) odly_q <= wdata_i[HOLD_W-1:0];
    end
  end

  always_comb begin
    rdata_d = '0;
    if (rd_i) begin
      case (addr_i)
        A_CFG:   rdata_d[CFG_W-1:0]  = cfg_q;
        A_LIM:   rdata_d[LIM_W-1:0]  = lim_q;
        A_DLY:   rdata_d[DLY_W-1:0]  = dly_q;
        A_STEP:  rdata_d[STEP_W-1:0] = step_q;
        A_IVL:   rdata_d[IVL_W-1:0]  = ivl_q;
        A_ODLY:  rdata_d[HOLD_W-1:0] = odly_q;
        default: rdata_d = '0;
      endcase
    end
  end

  assign rdata_o    = rdata_d;
  assign mode_o     = cfg_q[1:0];
  assign fast_sel_o = cfg_q[B_FAST];
  assign upd_pend_o = cfg_q[B_UPD];
  assign duty_o     = lim_q[PH_W-1:0];
  assign hold_ld_o  = dly_q[PRE_W-1:0];
  assign outdly_o   = odly_q;

endmodule

// File: rtl/led_pwm_tick_sel.sv
module led_pwm_tick_sel (
  input  logic fast_i,
  input  logic slow_i,
  input  logic sel_fast_i,
  output logic tick_o
);

  assign tick_o = sel_fast_i ? fast_i : slow_i;

endmodule

// File: rtl/led_pwm_core.sv
module led_pwm_core
  import led_pwm_pkg::*;
#(
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned PH_W   = 8,
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [1:0]        mode_i,
  input  logic [PH_W-1:0]   duty_i,
  input  logic              pend_i,
  input  logic              clr_i,
  input  logic [PRE_W-1:0]  hold_ld_i,
  input  logic [HOLD_W-1:0] outdly_i,
  output logic              commit_o,
  output logic              holding_o,
  output logic [PH_W-1:0]   phase_o,
  output logic [PRE_W-1:0]  ld_o,
  output logic              led_o
);

  localparam logic [PH_W-1:0] PH_MAX = {PH_W{1'b1}};

  logic [PRE_W-1:0]  pre_q, pre_d, ld_q, ld_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              led_q, led_d;
  logic              off, parked, pre_wrap, period_end;

  assign off        = (mode_i == MODE_OFF) || (mode_i == MODE_ALT_OFF);
  assign holding_o  = (hold_q != '0);
  assign parked     = off || holding_o;
  assign pre_wrap   = (pre_q == ld_q);
  assign period_end = tick_i && pre_wrap && (phase_q == PH_MAX);
  assign commit_o   = pend_i && !clr_i && (parked || period_end);

  // Counter next state
  always_comb begin
    pre_d   = pre_q;
    phase_d = phase_q;
    hold_d  = hold_q;
    ld_d    = ld_q;
    if (commit_o) ld_d = hold_ld_i;
    if (clr_i) begin
      pre_d   = '0;
      phase_d = '0;
      ld_d    = '0;
      if (off) hold_d = outdly_i;
    end else if (off) begin
      pre_d   = '0;
      phase_d = '0;
      hold_d  = outdly_i;
    end else if (holding_o) begin
      if (tick_i) hold_d = hold_q - HOLD_W'(1);
    end else if (tick_i) begin
      if (pre_wrap) begin
        pre_d   = '0;
        phase_d = phase_q + PH_W'(1);
      end else begin
        pre_d   = pre_q + PRE_W'(1);
      end
    end
  end

  // Pin next state, saturating end codes
  always_comb begin
    if (parked)                  led_d = 1'b0;
    else if (mode_i == MODE_ON)  led_d = 1'b1;
    else if (duty_i == '0)       led_d = 1'b0;
    else if (duty_i == PH_MAX)   led_d = 1'b1;
    else                         led_d = (phase_q < duty_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      phase_q <= '0;
      hold_q  <= '0;
      ld_q    <= '0;
      led_q   <= 1'b0;
    end else begin
      pre_q   <= pre_d;
      phase_q <= phase_d;
      hold_q  <= hold_d;
      ld_q    <= ld_d;
      led_q   <= led_d;
    end
  end

  assign phase_o = phase_q;
  assign ld_o    = ld_q;
  assign led_o   = led_q;

endmodule

// File: rtl/led_pwm_gen.sv
module led_pwm_gen
  import led_pwm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned PH_W   = 8,
  parameter int unsigned HOLD_W = 8,
  parameter int unsigned LIM_W  = 16,
  parameter int unsigned DLY_W  = 24,
  parameter int unsigned STEP_W = 32,
  parameter int unsigned IVL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              led_o
);

  logic              rst_meta_q, rst_sync_n;
  logic [1:0]        cfg_mode;
  logic              fast_sel, upd_pend, clr_pulse, commit, tick;
  logic              core_holding;
  logic [PH_W-1:0]   duty, phase;
  logic [PRE_W-1:0]  hold_ld, act_ld;
  logic [HOLD_W-1:0] outdly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  led_pwm_regs #(
    .DATA_W(DATA_W), .PRE_W(PRE_W), .PH_W(PH_W), .HOLD_W(HOLD_W),
    .LIM_W(LIM_W), .DLY_W(DLY_W), .STEP_W(STEP_W), .IVL_W(IVL_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_i(bus_wr_i), .rd_i(bus_rd_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .commit_i(commit),
    .mode_o(cfg_mode), .fast_sel_o(fast_sel), .upd_pend_o(upd_pend), .clr_o(clr_pulse),
    .duty_o(duty), .hold_ld_o(hold_ld), .outdly_o(outdly), .rdata_o(bus_rdata_o)
  );

  led_pwm_tick_sel tick_i (
    .fast_i(fast_tick_i), .slow_i(slow_tick_i), .sel_fast_i(fast_sel), .tick_o(tick)
  );

  led_pwm_core #(.PRE_W(PRE_W), .PH_W(PH_W), .HOLD_W(HOLD_W)) core_i (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(tick), .mode_i(cfg_mode), .duty_i(duty),
    .pend_i(upd_pend), .clr_i(clr_pulse), .hold_ld_i(hold_ld), .outdly_i(outdly),
    .commit_o(commit), .holding_o(core_holding), .phase_o(phase), .ld_o(act_ld),
    .led_o(led_o)
  );

endmodule

// File: rtl/led_pwm_chk.sv
module led_pwm_chk #(
  parameter int unsigned PRE_W = 12,
  parameter int unsigned PH_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [PH_W-1:0]  duty,
  input logic             holding,
  input logic             pend,
  input logic             clr,
  input logic             commit,
  input logic [PRE_W-1:0] ld,
  input logic [PRE_W-1:0] hold_ld,
  input logic [PH_W-1:0]  phase,
  input logic             led
);

  // R2: off codes give a low pin on the next clock
  p_off_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] == 1'b0) |=> !led);

  // R2: always-on code gives a high pin once the hold has expired
  p_on_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !holding) |=> led);

  // R4: saturating end codes
  p_duty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !holding && duty == '0) |=> !led);
  p_duty_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !holding && duty == '1) |=> led);

  // R5: active prescale moves only on a request or a clear
  p_ld_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !clr) |=> $stable(ld));

  // R6: a transfer loads the held value
  p_commit_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (ld == $past(hold_ld)));

  // R8: clear restarts at phase 0 with prescale 0
  p_clr_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase == '0 && ld == '0));

  // R11: the off state parks the phase at the period start
  p_entry_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] == 1'b0) |=> (phase == '0));

endmodule

bind led_pwm_gen led_pwm_chk #(.PRE_W(PRE_W), .PH_W(PH_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .mode(cfg_mode), .duty(duty), .holding(core_holding),
  .pend(upd_pend), .clr(clr_pulse), .commit(commit), .ld(act_ld), .hold_ld(hold_ld),
  .phase(phase), .led(led_o)
);

// File: tb/led_pwm_gen_tb_top.sv
`timescale 1ns/1ps
module led_pwm_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast_tick = 1'b1;
  logic        slow_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        led;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  bit  slow_en = 1'b0;

  always #2.5 clk = ~clk;

  led_pwm_gen dut_i (
    .clk(clk), .rst_n(rst_n), .fast_tick_i(fast_tick), .slow_tick_i(slow_tick),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .led_o(led)
  );

  // Slow tick: one pulse every fourth clock while enabled
  initial begin
    int sdiv = 0;
    forever begin
      @(negedge clk);
      if (slow_en) begin
        sdiv = (sdiv + 1) % 4;
        slow_tick = (sdiv == 0);
      end else begin
        slow_tick = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic window(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (led === 1'b1) c++;
    end
  endtask

  task automatic high_run(output int len);
    int g = 0;
    while (led === 1'b1 && g < 20000) begin @(negedge clk); g++; end
    while (led !== 1'b1 && g < 20000) begin @(negedge clk); g++; end
    len = 0;
    while (led === 1'b1 && len < 20000) begin len++; @(negedge clk); end
  endtask

  task automatic setup(input int ld, input int duty, input int mode);
    wr(3'd0, 32'h4);
    wr(3'd2, ld);
    wr(3'd1, duty);
    wr(3'd0, 32'h44);
    wr(3'd0, 32'h4 | mode);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c, len, exp;
    int duties [9] = '{0, 1, 2, 100, 127, 128, 200, 254, 255};

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 cfg reset", v, 32'h1400);
    rd(3'd1, v); check("R1 limits reset", v, 0);
    rd(3'd2, v); check("R1 delay reset", v, 0);
    rd(3'd5, v); check("R1 outdly reset", v, 0);
    check("R1 led reset", {31'b0, led}, 0);

    // R9 register widths
    wr(3'd0, 32'hFFFFAB38); rd(3'd0, v); check("R9 cfg mask", v, 32'h0001AB38);
    wr(3'd1, 32'hFFFFFFFF); rd(3'd1, v); check("R9 limits mask", v, 32'h0000FFFF);
    wr(3'd2, 32'hFFFFFFFF); rd(3'd2, v); check("R9 delay mask", v, 32'h00FFFFFF);
    wr(3'd3, 32'h12345678); rd(3'd3, v); check("R9 step store", v, 32'h12345678);
    wr(3'd4, 32'hCAFEBABE); rd(3'd4, v); check("R9 interval mask", v, 32'h0000BABE);
    wr(3'd5, 32'hFFFFFF5A); rd(3'd5, v); check("R9 outdly mask", v, 32'h5A);
    rd(3'd6, v); check("R9 unused offset", v, 0);
    @(negedge clk); check("R9 no strobe", bus_rdata, 0);
    wr(3'd5, 32'h0);

    // R2 mode decode
    setup(0, 255, 1);
    repeat (2) @(negedge clk);
    window(300, c); check("R2 code1 off", c, 0);
    wr(3'd1, 0); wr(3'd0, 32'h7);
    repeat (2) @(negedge clk);
    window(300, c); check("R2 code3 on", c, 300);
    wr(3'd1, 255); wr(3'd0, 32'h4);
    repeat (2) @(negedge clk);
    window(300, c); check("R2 code0 off", c, 0);

    // R3/R4 sweep over prescale and duty
    for (int ld = 0; ld < 3; ld++) begin
      foreach (duties[k]) begin
        setup(ld, duties[k], 2);
        repeat (2) @(negedge clk);
        window(256 * (ld + 1), c);
        if (duties[k] == 255) exp = 256 * (ld + 1);
        else                  exp = duties[k] * (ld + 1);
        if (duties[k] == 0 || duties[k] == 255) check("R4 end code count", c, exp);
        else begin
          check("R3 high count", c, exp);
          high_run(len); check("R3 high run", len, exp);
        end
      end
    end

    // R10 slow tick selection, fast tick left active
    setup(0, 64, 2);
    slow_en = 1'b1;
    wr(3'd0, 32'h2);
    high_run(len); check("R10 slow tick run", len, 256);
    slow_en = 1'b0;

    // R5/R6 shadowed prescale
    setup(0, 128, 2);
    high_run(len); check("R5 base run", len, 128);
    wr(3'd2, 3);
    high_run(len); check("R5 held write run", len, 128);
    high_run(len); check("R5 held write run 2", len, 128);
    wr(3'd0, 32'h46);
    high_run(len); check("R6 committed run", len, 512);
    rd(3'd0, v); check("R6 request cleared", v, 32'h6);

    // R6 request pending while no tick arrives; write of 0 keeps it
    wr(3'd0, 32'h42); rd(3'd0, v); check("R6 request pending", v, 32'h42);
    wr(3'd0, 32'h02); rd(3'd0, v); check("R6 zero keeps request", v, 32'h42);
    wr(3'd0, 32'h46);
    repeat (1100) @(negedge clk);
    rd(3'd0, v); check("R6 request taken", v, 32'h6);

    // R7 immediate duty
    setup(3, 0, 2);
    repeat (10) @(negedge clk);
    wr(3'd1, 255);
    @(negedge clk); check("R7 duty up", {31'b0, led}, 1);
    wr(3'd1, 0);
    @(negedge clk); check("R7 duty down", {31'b0, led}, 0);

    // R8 counter clear
    setup(3, 128, 2);
    high_run(len); check("R8 before clear", len, 512);
    repeat (37) @(negedge clk);
    wr(3'd0, 32'h86);
    @(negedge clk); check("R8 phase 0 high", {31'b0, led}, 1);
    len = 0;
    while (led === 1'b1 && len < 20000) begin len++; @(negedge clk); end
    check("R8 prescale zero run", len, 128);
    rd(3'd0, v); check("R8 clear reads 0", v, 32'h6);

    // R11 start-up hold
    wr(3'd0, 32'h4); wr(3'd5, 5); wr(3'd1, 255);
    wr(3'd0, 32'h6);
    c = 0;
    while (led !== 1'b1 && c < 100) begin c++; @(negedge clk); end
    check("R11 hold 5", c, 6);
    wr(3'd0, 32'h4); wr(3'd5, 0);
    wr(3'd0, 32'h6);
    c = 0;
    while (led !== 1'b1 && c < 100) begin c++; @(negedge clk); end
    check("R11 hold 0", c, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule